// File: doc/BRIEF.md
# Integer HINT and Reserved Encoding Classifier

This block examines one 32-bit instruction word of the 64-bit base integer set. It reports whether that word falls in the standard HINT space, the custom HINT space or a reserved encoding. The result is captured in a register, so the three flags reflect the word that was presented at the previous rising clock edge. A pipeline can use the HINT flags to turn those code points into no-ops. It can handle the reserved flag in whatever way it prefers.

Only the integer computational groups and the memory-ordering fence are classified. Opcodes are taken from bits 6..0: 0110111 upper-immediate load, 0010111 pc-relative upper add, 0010011 immediate ALU, 0011011 word immediate ALU, 0110011 register ALU, 0111011 word register ALU, and 0001111 for the fence. Every other word produces all-zero flags.

Top module: `insn_hint_classifier`

## Requirements
- R1: Synchronous active-high reset clears all three flags. Each flag reflects the word sampled at the previous rising edge, with exactly one cycle of latency.
- R2: Upper-immediate load (0110111) and pc-relative upper add (0010111) with destination field (bits 11..7) equal to zero raise the standard flag. With a nonzero destination they raise no flag.
- R3: Immediate add (opcode 0010011, funct3 000) with a zero destination raises the standard flag only when the source field (bits 19..15) or the 12-bit immediate (bits 31..20) is nonzero. The canonical no-op 0x00000013 raises no flag.
- R4: Immediate XOR/OR/AND (funct3 100/110/111 of 0010011) and word immediate add (funct3 000 of 0011011) with a zero destination raise the standard flag.
- R5: Immediate set-less-than, signed and unsigned (funct3 010/011 of 0010011), and full-width immediate shifts with a zero destination raise the custom flag. The shifts are funct3 001 with bits 31..26 = 000000, and funct3 101 with bits 31..26 = 000000 or 010000. A shift with any other upper field raises no flag.
- R6: Word immediate shifts (0011011) are funct3 001 with bits 31..25 = 000000x, and funct3 101 with bits 31..25 = 000000x or 010000x. When bit 25 is one they raise the reserved flag, whatever the destination. When bit 25 is zero and the destination is zero they raise the custom flag.
- R7: Register operations with a zero destination raise the standard flag. On 0110011 these are funct7 0000000 with any funct3, and funct7 0100000 with funct3 000/101. On 0111011 these are funct7 0000000 with funct3 000/001/101, and funct7 0100000 with funct3 000/101. The exception is register set-less-than (funct7 0000000, funct3 010/011 of 0110011), which raises the custom flag. Other funct7 values raise no flag.
- R8: A fence (0001111, funct3 000) with mode bits 31..28 zero, and either predecessor set (bits 27..24) or successor set (bits 23..20) zero, raises the standard flag in three situations: destination zero with source nonzero; destination nonzero with source zero; or both zero. A fence with both fields nonzero, a nonzero mode, both sets nonzero, or another funct3 raises no flag.
- R9: The fence with zero destination and source, zero mode, predecessor exactly 0001 (write only) and successor zero (word 0x0100000F) raises the standard flag. Predecessor 0001 with successor 0001 raises none.
- R10: At most one flag is raised for any word, and words with any other opcode raise none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word to classify |
| hint_std_o | output | 1 | Registered standard-HINT flag |
| hint_custom_o | output | 1 | Registered custom-HINT flag |
| rsv_enc_o | output | 1 | Registered reserved-encoding flag |

## Verification
Every flag is due exactly one rising edge after its word is applied. The bench changes the word on a falling edge and compares the flags on the following falling edge, half a period after the capturing edge. The latency check looks 1 ns after driving, to confirm nothing has moved yet, and 1 ns after the next rising edge, where the new value must already be present. Reset is asserted while a HINT word is applied, and the flags must read zero on the falling edge after the reset edge.

// File: rtl/insn_hint_pkg.sv
package insn_hint_pkg;

  localparam int unsigned ILEN    = 32;
  localparam int unsigned OPC_W   = 7;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned F3_W    = 3;
  localparam int unsigned F7_W    = 7;
  localparam int unsigned ORD_W   = 4;   // fence set / mode width
  localparam int unsigned IMM_W   = F7_W + REG_W;

  localparam logic [OPC_W-1:0] OPC_LUI     = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC   = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_IMM     = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_IMM_W   = 7'b0011011;
  localparam logic [OPC_W-1:0] OPC_REG     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_REG_W   = 7'b0111011;
  localparam logic [OPC_W-1:0] OPC_ORDER   = 7'b0001111;

  localparam logic [F7_W-1:0]  F7_BASE     = 7'b0000000;
  localparam logic [F7_W-1:0]  F7_ALT      = 7'b0100000;
  localparam logic [ORD_W-1:0] SET_W_ONLY  = 4'b0001;

  typedef struct packed {
    logic [F7_W-1:0]  funct7;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rs1;
    logic [F3_W-1:0]  funct3;
    logic [REG_W-1:0] rd;
    logic [OPC_W-1:0] opcode;
  } insn_fields_t;

  typedef struct packed {
    logic std_hint;
    logic cust_hint;
    logic rsv_enc;
  } hint_flags_t;

endpackage

// File: rtl/hint_imm_class.sv
module hint_imm_class
  import insn_hint_pkg::*;
(
  input  insn_fields_t f,
  output hint_flags_t  flags
);

  logic             rd_zero;
  logic [IMM_W-1:0] imm12;
  logic [F7_W-2:0]  hi6;
  logic             hi6_left_ok;
  logic             hi6_right_ok;

  assign rd_zero      = (f.rd == '0);
  assign imm12        = {f.funct7, f.rs2};
  assign hi6          = f.funct7[F7_W-1:1];
  assign hi6_left_ok  = (hi6 == F7_BASE[F7_W-1:1]);
  assign hi6_right_ok = hi6_left_ok || (hi6 == F7_ALT[F7_W-1:1]);

  always_comb begin
    flags = '0;
    unique case (f.opcode)
      OPC_LUI, OPC_AUIPC: flags.std_hint = rd_zero;
      OPC_IMM: begin
        unique case (f.funct3)
          3'b000:                 flags.std_hint  = rd_zero && ((f.rs1 != '0) || (imm12 != '0));
          3'b100, 3'b110, 3'b111: flags.std_hint  = rd_zero;
          3'b010, 3'b011:         flags.cust_hint = rd_zero;
          3'b001:                 flags.cust_hint = rd_zero && hi6_left_ok;
          3'b101:                 flags.cust_hint = rd_zero && hi6_right_ok;
          default:                flags = '0;
        endcase
      end
      OPC_IMM_W: begin
        unique case (f.funct3)
          3'b000: flags.std_hint = rd_zero;
          3'b001: begin
            flags.rsv_enc   = hi6_left_ok && f.funct7[0];
            flags.cust_hint = hi6_left_ok && !f.funct7[0] && rd_zero;
          end
          3'b101: begin
            flags.rsv_enc   = hi6_right_ok && f.funct7[0];
            flags.cust_hint = hi6_right_ok && !f.funct7[0] && rd_zero;
          end
          default: flags = '0;
        endcase
      end
      default: flags = '0;
    endcase
  end

endmodule

// File: rtl/hint_reg_class.sv
module hint_reg_class
  import insn_hint_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic [F7_W-1:0]  funct7,
  input  logic [REG_W-1:0] rd,
  output hint_flags_t      flags
);

  logic rd_zero;
  logic f3_add_or_sr;
  logic f3_slt;

  assign rd_zero      = (rd == '0);
  assign f3_add_or_sr = (funct3 == 3'b000) || (funct3 == 3'b101);
  assign f3_slt       = (funct3 == 3'b010) || (funct3 == 3'b011);

  always_comb begin
    flags = '0;
    if (opcode == OPC_REG) begin
      if (funct7 == F7_BASE) begin
        flags.cust_hint = rd_zero && f3_slt;
        flags.std_hint  = rd_zero && !f3_slt;
      end else if (funct7 == F7_ALT) begin
        flags.std_hint  = rd_zero && f3_add_or_sr;
      end
    end else if (opcode == OPC_REG_W) begin
      if (funct7 == F7_BASE) begin
        flags.std_hint = rd_zero && (f3_add_or_sr || (funct3 == 3'b001));
      end else if (funct7 == F7_ALT) begin
        flags.std_hint = rd_zero && f3_add_or_sr;
      end
    end
  end

endmodule

// File: rtl/hint_fence_class.sv
module hint_fence_class
  import insn_hint_pkg::*;
(
  input  insn_fields_t f,
  output hint_flags_t  flags
);

  logic [ORD_W-1:0] mode;
  logic [ORD_W-1:0] pred;
  logic [ORD_W-1:0] succ;
  logic             is_fence;
  logic             base_ok;
  logic             rd_z, rs_z;
  logic             case_src_only, case_dst_only, case_pred_empty, case_succ_empty, case_pause;

  assign mode     = f.funct7[F7_W-1 -: ORD_W];
  assign pred     = {f.funct7[F7_W-ORD_W-1:0], f.rs2[REG_W-1]};
  assign succ     = f.rs2[ORD_W-1:0];
  assign is_fence = (f.opcode == OPC_ORDER) && (f.funct3 == '0);
  assign base_ok  = is_fence && (mode == '0) && ((pred == '0) || (succ == '0));
  assign rd_z     = (f.rd == '0);
  assign rs_z     = (f.rs1 == '0);

  always_comb begin
    case_src_only   = base_ok && rd_z && !rs_z;
    case_dst_only   = base_ok && !rd_z && rs_z;
    case_pred_empty = base_ok && rd_z && rs_z && (pred == '0) && (succ != '0);
    case_succ_empty = base_ok && rd_z && rs_z && (succ == '0) && (pred != SET_W_ONLY);
    case_pause      = base_ok && rd_z && rs_z && (succ == '0) && (pred == SET_W_ONLY);
    flags           = '0;
    flags.std_hint  = case_src_only || case_dst_only || case_pred_empty ||
                      case_succ_empty || case_pause;
  end

endmodule

// File: rtl/insn_hint_classifier.sv
module insn_hint_classifier
  import insn_hint_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ILEN-1:0] insn_i,
  output logic            hint_std_o,
  output logic            hint_custom_o,
  output logic            rsv_enc_o
);

  localparam logic [ILEN-1:0] NOP_WORD   = 32'h0000_0013;
  localparam logic [ILEN-1:0] PAUSE_WORD = 32'h0100_000F;

  insn_fields_t fld;
  hint_flags_t  imm_flags, reg_flags, ord_flags, next_flags;

  assign fld = insn_fields_t'(insn_i);

  hint_imm_class u_imm (
    .f     (fld),
    .flags (imm_flags)
  );

  hint_reg_class u_reg (
    .opcode (fld.opcode),
    .funct3 (fld.funct3),
    .funct7 (fld.funct7),
    .rd     (fld.rd),
    .flags  (reg_flags)
  );

  hint_fence_class u_ord (
    .f     (fld),
    .flags (ord_flags)
  );

  // opcodes are disjoint between the classifiers, so OR merges them
  assign next_flags = imm_flags | reg_flags | ord_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      hint_std_o    <= 1'b0;
      hint_custom_o <= 1'b0;
      rsv_enc_o     <= 1'b0;
    end else begin
      hint_std_o    <= next_flags.std_hint;
      hint_custom_o <= next_flags.cust_hint;
      rsv_enc_o     <= next_flags.rsv_enc;
    end
  end

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hint_std_o, hint_custom_o, rsv_enc_o}));

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(hint_std_o || hint_custom_o || rsv_enc_o));

  assert_rsv_word_shift_R6: assert property (@(posedge clk) disable iff (rst)
    rsv_enc_o |-> ($past(insn_i[6:0]) == OPC_IMM_W) && $past(insn_i[25]));

  assert_custom_rd_zero_R5: assert property (@(posedge clk) disable iff (rst)
    hint_custom_o |-> ($past(insn_i[11:7]) == '0));

  assert_nop_not_hint_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(insn_i) == NOP_WORD) |-> !hint_std_o);

  assert_pause_std_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(insn_i) == PAUSE_WORD)) |-> hint_std_o);

endmodule

// File: tb/insn_hint_classifier_tb.sv
`timescale 1ns/1ps
module insn_hint_classifier_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic        hs, hc, rv;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  insn_hint_classifier u_dut (
    .clk           (clk),
    .rst           (rst),
    .insn_i        (insn),
    .hint_std_o    (hs),
    .hint_custom_o (hc),
    .rsv_enc_o     (rv)
  );

  localparam logic [2:0] S = 3'b100, C = 3'b010, V = 3'b001, Z = 3'b000;
  localparam logic [6:0] LUI = 7'b0110111, AUI = 7'b0010111, OI = 7'b0010011,
                         OIW = 7'b0011011, OR_ = 7'b0110011, ORW = 7'b0111011;

  function automatic logic [31:0] ity(input logic [11:0] im, input logic [4:0] s1,
                                      input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {im, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] rty(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [4:0] d, input logic [6:0] op);
    return {f7, 5'd6, 5'd4, f3, d, op};
  endfunction
  function automatic logic [31:0] uty(input logic [4:0] d, input logic [6:0] op);
    return {20'hABCDE, d, op};
  endfunction
  function automatic logic [31:0] fty(input logic [3:0] fm, input logic [3:0] p, input logic [3:0] s,
                                      input logic [4:0] s1, input logic [4:0] d);
    return {fm, p, s, s1, 3'b000, d, 7'b0001111};
  endfunction
  function automatic logic [38:0] v(input logic [3:0] r, input logic [2:0] e, input logic [31:0] w);
    return {r, e, w};
  endfunction

  localparam int NV = 52;
  localparam logic [38:0] VEC [NV] = '{
    v(2, S, uty(0, LUI)), v(2, Z, uty(5, LUI)), v(2, S, uty(0, AUI)), v(2, Z, uty(1, AUI)),        // R2
    v(3, Z, ity(12'h000, 0, 3'b000, 0, OI)), v(3, S, ity(12'h000, 3, 3'b000, 0, OI)),            // R3
    v(3, S, ity(12'h001, 0, 3'b000, 0, OI)), v(3, S, ity(12'hFFF, 0, 3'b000, 0, OI)),
    v(3, Z, ity(12'h005, 0, 3'b000, 7, OI)),
    v(4, S, ity(12'h0F0, 2, 3'b100, 0, OI)), v(4, S, ity(12'h0F0, 2, 3'b110, 0, OI)),            // R4
    v(4, S, ity(12'h0F0, 2, 3'b111, 0, OI)), v(4, Z, ity(12'h0F0, 2, 3'b111, 2, OI)),
    v(4, S, ity(12'h000, 0, 3'b000, 0, OIW)),
    v(5, C, ity(12'h010, 1, 3'b010, 0, OI)), v(5, C, ity(12'h010, 1, 3'b011, 0, OI)),            // R5
    v(5, Z, ity(12'h010, 1, 3'b010, 3, OI)), v(5, C, ity({6'b000000, 6'd63}, 1, 3'b001, 0, OI)),
    v(5, C, ity({6'b000000, 6'd1}, 1, 3'b101, 0, OI)), v(5, C, ity({6'b010000, 6'd40}, 1, 3'b101, 0, OI)),
    v(5, Z, ity({6'b010000, 6'd2}, 1, 3'b001, 0, OI)),
    v(6, C, ity({7'b0000000, 5'd7}, 1, 3'b001, 0, OIW)), v(6, C, ity({7'b0100000, 5'd3}, 1, 3'b101, 0, OIW)), // R6
    v(6, V, ity({7'b0000001, 5'd1}, 1, 3'b101, 0, OIW)), v(6, V, ity({7'b0100001, 5'd0}, 1, 3'b101, 9, OIW)),
    v(6, Z, ity({7'b0000000, 5'd2}, 1, 3'b001, 4, OIW)),
    v(7, S, rty(7'h00, 3'b000, 0, OR_)), v(7, S, rty(7'h20, 3'b000, 0, OR_)),                    // R7
    v(7, S, rty(7'h20, 3'b101, 0, OR_)), v(7, C, rty(7'h00, 3'b010, 0, OR_)),
    v(7, C, rty(7'h00, 3'b011, 0, OR_)), v(7, Z, rty(7'h00, 3'b000, 1, OR_)),
    v(7, Z, rty(7'h01, 3'b000, 0, OR_)), v(7, S, rty(7'h00, 3'b000, 0, ORW)),
    v(7, S, rty(7'h20, 3'b000, 0, ORW)), v(7, S, rty(7'h20, 3'b101, 0, ORW)),
    v(7, Z, rty(7'h00, 3'b010, 0, ORW)),
    v(8, S, fty(0, 4'h0, 4'h3, 1, 0)), v(8, S, fty(0, 4'h3, 4'h0, 0, 2)),                        // R8
    v(8, S, fty(0, 4'h0, 4'h5, 0, 0)), v(8, S, fty(0, 4'h8, 4'h0, 0, 0)),
    v(8, S, fty(0, 4'h0, 4'h0, 0, 0)), v(8, Z, fty(0, 4'h0, 4'h1, 1, 1)),
    v(8, Z, fty(4'h8, 4'h0, 4'h1, 0, 0)), v(8, Z, fty(0, 4'h3, 4'h3, 5, 0)),
    v(8, Z, fty(0, 4'hF, 4'hF, 0, 0)), v(8, Z, {12'h000, 5'd0, 3'b001, 5'd0, 7'b0001111}),
    v(9, S, 32'h0100_000F), v(9, Z, fty(0, 4'h1, 4'h1, 0, 0)),                                   // R9
    v(10, Z, ity(12'h000, 0, 3'b000, 0, 7'b0000011)), v(10, Z, ity(12'h000, 0, 3'b000, 0, 7'b0100011)), // R10
    v(10, Z, ity(12'h000, 0, 3'b000, 0, 7'b1100011))
  };

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: flags {std,cust,rsv} got %b expected %b (insn %h)", req, got, exp, insn);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: flags held at zero while reset is applied with a HINT word present
    insn = uty(0, LUI);
    repeat (3) @(negedge clk);
    chk("R1", {hs, hc, rv}, Z);
    rst = 1'b0;

    // table walk, one word per cycle
    for (int i = 0; i < NV; i++) begin
      insn = VEC[i][31:0];
      @(negedge clk);
      chk($sformatf("R%0d", VEC[i][38:35]), {hs, hc, rv}, VEC[i][34:32]);
      checks++;
      if ($countones({hs, hc, rv}) > 1) begin
        errors++;
        $display("FAIL R10: got %0d flags expected at most 1", $countones({hs, hc, rv}));
      end
    end

    // R1: one cycle latency
    insn = 32'h0000_0013;
    @(negedge clk);
    insn = rty(7'h00, 3'b010, 0, OR_);
    #1 chk("R1 before edge", {hs, hc, rv}, Z);
    @(posedge clk);
    #1 chk("R1 after edge", {hs, hc, rv}, C);

    // R6: reserved raised, then cleared on the next word
    @(negedge clk);
    insn = ity({7'b0000001, 5'd4}, 2, 3'b001, 3, OIW);
    @(negedge clk);
    chk("R6 reserved slliw", {hs, hc, rv}, V);
    insn = uty(3, LUI);
    @(negedge clk);
    chk("R2 clears", {hs, hc, rv}, Z);

    // R1: mid-run reset
    insn = rty(7'h00, 3'b000, 0, OR_);
    @(negedge clk);
    chk("R7 pre-reset", {hs, hc, rv}, S);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", {hs, hc, rv}, Z);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {hs, hc, rv}, S);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule